// File: doc/BRIEF.md
# Per-Channel Static-Run Auto-Mute with Mute-Pin Mapper

This block sits beside a six-channel DAC datapath. It watches each channel's signed sample stream. It mutes a channel on its own once that channel has carried a long unbroken run of digital silence, either all-zero or all-ones (minus one). Any sample that is not one of those two values releases the mute at once. The automatic mute is ORed with a manual mute bit for each channel and with one global mute bit. The result is six registered mute states, one per channel, which the volume stage downstream uses.

A shared mute-indicator pin summarises the channel states. A channel mask selects which channels take part. The pin is active only when every selected channel is muted. When the mask selects no channel at all, the pin is forced active. A polarity input picks whether the active level is high or low.

The run length is a parameter and defaults to 8192 samples. Samples count only in cycles where the sample strobe is high.

Top module: `dac_automute_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every `ch_mute` bit and `mute_pin` read 0.
- R2: With `auto_en` high, a channel whose strobed samples are all zero mutes after exactly RUN_LEN consecutive such samples. After RUN_LEN-1 samples it is not muted. The mute appears on `ch_mute` two rising edges after the strobe edge of the last sample.
- R3: A run of RUN_LEN consecutive strobed samples equal to minus one (all bits set) also mutes the channel.
- R4: A strobed sample that switches between the two silent values (zero to minus one, or back) restarts the run. The channel then needs RUN_LEN further samples of the new value.
- R5: One strobed sample that is neither zero nor minus one clears that channel's automatic mute. The bit drops two rising edges after that strobe edge.
- R6: Each channel detects and mutes independently. A channel carrying non-silent samples stays unmuted while the others auto-mute.
- R7: While `auto_en` is low, no channel is muted automatically and every run count is cleared. After `auto_en` is raised again, a full new run is needed.
- R8: `man_mute[i]` high mutes channel i from the next rising edge, whatever the samples.
- R9: `glob_mute` high mutes all channels from the next rising edge.
- R10: When `pin_mask` is nonzero, the pin is active exactly when every channel whose mask bit is 1 is muted. Channels with mask bit 0 have no effect. The pin follows the mute states one rising edge later.
- R11: When `pin_mask` is all zero, the pin is active regardless of the mute states.
- R12: `pin_pol` = 1 makes the active level 1, and `pin_pol` = 0 makes the active level 0, so the inactive level is the complement.
- R13: Sample values presented while `smp_stb` is low are ignored. A non-silent value without the strobe does not release a mute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | Sample strobe; samples count only when high |
| smp_bus | input | NUM_CH*SMP_W (144) | Channel i sample at bits [i*SMP_W +: SMP_W], two's complement |
| auto_en | input | 1 | Enables static-run auto-mute |
| man_mute | input | NUM_CH (6) | Manual mute per channel |
| glob_mute | input | 1 | Mutes every channel |
| pin_mask | input | NUM_CH (6) | Selects channels mapped to the mute pin |
| pin_pol | input | 1 | Active level of the mute pin (1 = high) |
| ch_mute | output | NUM_CH (6) | Registered mute state per channel |
| mute_pin | output | 1 | Shared mute indicator |

## Verification
On every cycle, the assertions check the combining and mapping rules. A manual or global request must show as a mute one edge later. With auto-mute off, a channel carries nothing but the manual and global requests. The pin must take the active level under an empty mask, and must be inactive whenever a mapped channel is unmuted. Run counting depends on thousands of past samples, so only the bench scenarios can show it. These cover the exact RUN_LEN boundary, the restart on a switch between zero and minus one, release by one live sample, and samples without the strobe. The polarity combinations are walked from a vector table.

// File: rtl/dac_automute_pkg.sv
package dac_automute_pkg;

    // which silent value the current run holds
    typedef enum logic {
        RUN_ZERO = 1'b0,
        RUN_ONES = 1'b1
    } run_kind_e;

    // translate an active/inactive indication into the pin level
    function automatic logic pin_level(input logic active, input logic pol_hi);
        return pol_hi ? active : ~active;
    endfunction

endpackage

// File: rtl/amute_run_det.sv
module amute_run_det
    import dac_automute_pkg::*;
#(
    parameter int SMP_W   = 24,
    parameter int RUN_LEN = 8192
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic [SMP_W-1:0] sample,
    input  logic             enable,
    output logic             run_full
);

    localparam int CNT_W = $clog2(RUN_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        run_kind_e        kind;
    } det_s;

    det_s st_d, st_q;
    logic is_zero, is_ones;

    always_comb begin
        is_zero = (sample == '0);
        is_ones = (sample == '1);
        st_d    = st_q;
        if (!enable) begin
            st_d.cnt = '0;
        end else if (stb) begin
            if (is_zero || is_ones) begin
                if ((st_q.cnt != '0) && (st_q.kind == (is_ones ? RUN_ONES : RUN_ZERO))) begin
                    if (st_q.cnt != CNT_MAX) begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end else begin
                    st_d.cnt  = CNT_W'(1);
                    st_d.kind = is_ones ? RUN_ONES : RUN_ZERO;
                end
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, kind: RUN_ZERO};
        end else begin
            st_q <= st_d;
        end
    end

    assign run_full = (st_q.cnt == CNT_MAX);

endmodule

// File: rtl/amute_combine.sv
module amute_combine #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] run_full,
    input  logic              auto_en,
    input  logic [NUM_CH-1:0] man_mute,
    input  logic              glob_mute,
    output logic [NUM_CH-1:0] mute
);

    typedef struct packed {
        logic [NUM_CH-1:0] mute;
    } cmb_s;

    cmb_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CH; i++) begin
            st_d.mute[i] = (run_full[i] & auto_en) | man_mute[i] | glob_mute;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mute = st_q.mute;

endmodule

// File: rtl/amute_pin_map.sv
module amute_pin_map
    import dac_automute_pkg::*;
#(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] mute,
    input  logic [NUM_CH-1:0] mask,
    input  logic              pol_hi,
    output logic              pin
);

    typedef struct packed {
        logic pin;
    } map_s;

    map_s st_d, st_q;
    logic active;

    always_comb begin
        st_d = st_q;
        if (mask == '0) begin
            active = 1'b1;
        end else begin
            active = ((mute & mask) == mask);
        end
        st_d.pin = pin_level(active, pol_hi);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin = st_q.pin;

endmodule

// File: rtl/dac_automute_top.sv
module dac_automute_top #(
    parameter int NUM_CH  = 6,
    parameter int SMP_W   = 24,
    parameter int RUN_LEN = 8192
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_stb,
    input  logic [NUM_CH*SMP_W-1:0] smp_bus,
    input  logic                    auto_en,
    input  logic [NUM_CH-1:0]       man_mute,
    input  logic                    glob_mute,
    input  logic [NUM_CH-1:0]       pin_mask,
    input  logic                    pin_pol,
    output logic [NUM_CH-1:0]       ch_mute,
    output logic                    mute_pin
);

    logic [NUM_CH-1:0] run_full;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_det
        amute_run_det #(
            .SMP_W  (SMP_W),
            .RUN_LEN(RUN_LEN)
        ) u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .stb     (smp_stb),
            .sample  (smp_bus[g*SMP_W +: SMP_W]),
            .enable  (auto_en),
            .run_full(run_full[g])
        );
    end

    amute_combine #(.NUM_CH(NUM_CH)) u_cmb (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_full (run_full),
        .auto_en  (auto_en),
        .man_mute (man_mute),
        .glob_mute(glob_mute),
        .mute     (ch_mute)
    );

    amute_pin_map #(.NUM_CH(NUM_CH)) u_map (
        .clk   (clk),
        .rst_n (rst_n),
        .mute  (ch_mute),
        .mask  (pin_mask),
        .pol_hi(pin_pol),
        .pin   (mute_pin)
    );

endmodule

// File: rtl/dac_automute_chk.sv
module dac_automute_chk #(
    parameter int NUM_CH = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              auto_en,
    input logic [NUM_CH-1:0] man_mute,
    input logic              glob_mute,
    input logic [NUM_CH-1:0] pin_mask,
    input logic              pin_pol,
    input logic [NUM_CH-1:0] ch_mute,
    input logic              mute_pin
);

    logic live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R9
    glob_all_muted_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        $past(glob_mute) |-> (&ch_mute));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // R8
        man_muted_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
            $past(man_mute[i]) |-> ch_mute[i]);
        // R7
        auto_off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
            (!$past(auto_en) && !$past(man_mute[i]) && !$past(glob_mute)) |-> !ch_mute[i]);
    end

    // R11
    empty_mask_active_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        ($past(pin_mask) == '0) |-> (mute_pin == $past(pin_pol)));

    // R10
    unmuted_mapped_idle_chk: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
        (($past(pin_mask) != '0) && (($past(ch_mute) & $past(pin_mask)) != $past(pin_mask)))
        |-> (mute_pin != $past(pin_pol)));

endmodule

bind dac_automute_top dac_automute_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .auto_en  (auto_en),
    .man_mute (man_mute),
    .glob_mute(glob_mute),
    .pin_mask (pin_mask),
    .pin_pol  (pin_pol),
    .ch_mute  (ch_mute),
    .mute_pin (mute_pin)
);

// File: tb/sim_dac_automute_top.sv
`timescale 1ns/1ps
module sim_dac_automute_top;

    localparam int NUM_CH  = 6;
    localparam int SMP_W   = 24;
    localparam int RUN_LEN = 8192;
    localparam int NVEC    = 9;

    // {mask[5:0], manual[5:0], pol, expected pin}
    localparam logic [13:0] VEC [NVEC] = '{
        {6'b000000, 6'b000000, 1'b1, 1'b1},
        {6'b000000, 6'b000000, 1'b0, 1'b0},
        {6'b000011, 6'b000001, 1'b1, 1'b0},
        {6'b000011, 6'b000011, 1'b1, 1'b1},
        {6'b000011, 6'b000011, 1'b0, 1'b0},
        {6'b000011, 6'b111100, 1'b1, 1'b0},
        {6'b111111, 6'b111111, 1'b1, 1'b1},
        {6'b100000, 6'b100000, 1'b0, 1'b0},
        {6'b100000, 6'b011111, 1'b0, 1'b1}
    };

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    smp_stb = 1'b0;
    logic [NUM_CH*SMP_W-1:0] smp_bus;
    logic                    auto_en = 1'b0;
    logic [NUM_CH-1:0]       man_mute = '0;
    logic                    glob_mute = 1'b0;
    logic [NUM_CH-1:0]       pin_mask = '0;
    logic                    pin_pol = 1'b1;
    logic [NUM_CH-1:0]       ch_mute;
    logic                    mute_pin;
    logic [SMP_W-1:0]        smp [NUM_CH];

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) smp_bus[i*SMP_W +: SMP_W] = smp[i];
    end

    dac_automute_top #(.NUM_CH(NUM_CH), .SMP_W(SMP_W), .RUN_LEN(RUN_LEN)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_bus(smp_bus),
        .auto_en(auto_en), .man_mute(man_mute), .glob_mute(glob_mute),
        .pin_mask(pin_mask), .pin_pol(pin_pol), .ch_mute(ch_mute), .mute_pin(mute_pin)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // present current samples with strobe for n edges
    task automatic feed(input int n);
        @(negedge clk);
        smp_stb = 1'b1;
        repeat (n) @(negedge clk);
        smp_stb = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired before completion");
            report();
        end
    end

    initial begin
        for (int i = 0; i < NUM_CH; i++) smp[i] = 24'h000005;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 mute in reset", {26'd0, ch_mute}, 32'd0);
        check("R1 pin in reset", {31'd0, mute_pin}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mute after reset", {26'd0, ch_mute}, 32'd0);

        // vector table: mapping, mask, polarity, manual mute (R8 R10 R11 R12)
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            pin_mask = VEC[v][13:8];
            man_mute = VEC[v][7:2];
            pin_pol  = VEC[v][1];
            settle();
            check("R8 manual mute state", {26'd0, ch_mute}, {26'd0, VEC[v][7:2]});
            check("R10 R11 R12 pin level", {31'd0, mute_pin}, {31'd0, VEC[v][0]});
        end
        man_mute = '0;
        pin_mask = 6'b000011;
        pin_pol  = 1'b1;

        // runs: ch0 zero, ch1 minus one, ch2 zero then switches, others live
        auto_en = 1'b1;
        smp[0] = 24'h000000;
        smp[1] = 24'hFFFFFF;
        smp[2] = 24'h000000;
        smp[3] = 24'h000007;
        smp[4] = 24'h800000;
        smp[5] = 24'h7FFFFF;
        feed(RUN_LEN - 1);
        settle();
        check("R2 not muted at RUN_LEN-1", {26'd0, ch_mute}, 32'd0);
        smp[2] = 24'hFFFFFF;
        feed(1);
        settle();
        check("R2 R3 R4 R6 mute after full run", {26'd0, ch_mute}, 32'h03);
        check("R10 pin with both mapped muted", {31'd0, mute_pin}, 32'd1);
        feed(RUN_LEN - 2);
        settle();
        check("R4 restarted run one short", {31'd0, ch_mute[2]}, 32'd0);
        feed(1);
        settle();
        check("R4 restarted run complete", {26'd0, ch_mute}, 32'h07);

        // R5: one live sample releases ch0, exact latency
        @(negedge clk);
        smp[0] = 24'h000001;
        smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
        check("R5 still muted one edge after", {31'd0, ch_mute[0]}, 32'd1);
        @(negedge clk);
        check("R5 released two edges after", {31'd0, ch_mute[0]}, 32'd0);
        check("R6 ch1 unaffected by release", {31'd0, ch_mute[1]}, 32'd1);
        @(negedge clk);
        check("R10 pin inactive with mapped ch0 unmuted", {31'd0, mute_pin}, 32'd0);

        // R13: live value without strobe does not release ch1
        smp[1] = 24'h000123;
        repeat (6) @(negedge clk);
        check("R13 no release without strobe", {31'd0, ch_mute[1]}, 32'd1);
        smp[1] = 24'hFFFFFF;

        // R9: global mute
        glob_mute = 1'b1;
        settle();
        check("R9 global mutes all", {26'd0, ch_mute}, 32'h3F);
        glob_mute = 1'b0;
        settle();
        check("R9 release of global", {26'd0, ch_mute}, 32'h06);

        // R7: disabling clears auto mute and counts
        auto_en = 1'b0;
        settle();
        check("R7 auto off clears mutes", {26'd0, ch_mute}, 32'd0);
        auto_en = 1'b1;
        feed(2);
        settle();
        check("R7 counts cleared on re-enable", {26'd0, ch_mute}, 32'd0);

        done = 1'b1;
        report();
    end

endmodule